// File: doc/BRIEF.md
# Vicinity Tag Inventory Slot and State Controller

This block decides whether a passive vicinity tag answers a reader request, and in which cycle. It receives request fields that a front end has already parsed: the flags byte, the command code, the manufacturer byte, the mask length and mask, an address-match result and a checksum verdict. It also receives strobes for start and end delimiters and for full-depth carrier pauses, plus the field-present level and a retention-expired level from the analog element that preserves the long-lived silent state.

The controller holds the tag in one of three powered states: Ready, Quiet or Quiet-Hold. Quiet-Hold survives a field dropout until retention runs out. When an inventory request arrives, the controller runs a 1-slot or 16-slot anticollision sequence. A slot counter is placed above the mask bits, and the combined value is compared with the low bits of the tag identifier. Each reply is held back by a fixed guard interval after the last delimiter. The output is a one-cycle reply strobe that carries a reply kind and a 72-bit payload for the serializer.

Top module: `inv_slot_ctrl`

## Requirements
- R1: After reset, with `field_on` high, the tag is in Ready. Dropping `field_on` sends Ready or Quiet to an unpowered state and suppresses `resp_fire`. When the field returns, the tag is in Ready.
- R2: A request is silent and leaves the state unchanged in any of these cases: `req_crc_ok` is low; flags bit 4 is set (select in normal requests, family filter in inventory); flags bit 3 (protocol extension) is set; or flags bit 7 is set.
- R3: An inventory request has command 0x01 and flags bit 2 set. With flags bit 5 clear it opens 16 slots starting at slot 0. Each `eof_seen` moves to the next slot, up to slot 15. The tag replies in the slot where `tag_uid[mask_len+3:0]` equals {slot[3:0], mask[mask_len-1:0]}.
- R4: With flags bit 5 set, an inventory request uses a single slot. The tag replies when `tag_uid[mask_len-1:0]` equals `mask[mask_len-1:0]`.
- R5: An inventory request is silent when the mask length exceeds 60 with 16 slots, or exceeds 64 with one slot.
- R6: `resp_fire` is a one-cycle strobe. It rises T1_CYC cycles after the cycle in which the triggering `req_valid` or `eof_seen` is sampled. A `full_mod` sampled while the tag is waiting restarts that count.
- R7: A `sof_seen` ends the anticollision sequence. Any pending slot reply is dropped, and later `eof_seen` strobes cause no reply.
- R8: Stay-quiet (0x02) moves the tag to Quiet only when flags bit 5 (addressed) is set and `req_uid_match` is high. In Quiet, inventory requests get no reply.
- R9: Reset-to-ready (0x26) returns the tag to Ready from any powered state, with or without the address flag. When the address flag is set, `req_uid_match` must be high. The command is answered with `resp_kind` 2 and a zero payload.
- R10: Quiet-hold (0xAA) enters Quiet-Hold from Ready or Quiet. It requires the address flag, a UID match and `req_mfg` equal to 0x16. A matching addressed stay-quiet moves Quiet-Hold to Quiet.
- R11: Quiet-Hold is restored when the field returns, provided `retain_expired` stayed low. If `retain_expired` was high during the dropout, the tag comes back in Ready.
- R12: An inventory reply has `resp_kind` 1 and `resp_payload` = {tag_uid, 8'h00}, with the zero storage-format byte in the low byte. Stay-quiet and quiet-hold never reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| field_on | input | 1 | High while the reader field powers the tag |
| retain_expired | input | 1 | High once the quiet-hold retention element has decayed |
| tag_uid | input | 64 | Tag identifier |
| req_valid | input | 1 | Strobe: a parsed request ended with its end delimiter |
| req_crc_ok | input | 1 | Checksum of the request was correct |
| req_flags | input | 8 | Request flags byte, bit 0 first |
| req_cmd | input | 8 | Command code |
| req_mfg | input | 8 | Manufacturer byte of quiet-hold |
| req_mask_len | input | 7 | Mask length in bits |
| req_mask | input | 64 | Mask value, right aligned |
| req_uid_match | input | 1 | Address field equals the tag UID |
| sof_seen | input | 1 | Strobe: start delimiter detected |
| eof_seen | input | 1 | Strobe: lone end delimiter (slot advance) |
| full_mod | input | 1 | Strobe: full-depth carrier pause detected |
| resp_fire | output | 1 | One-cycle strobe: start the reply |
| resp_kind | output | 2 | 0 none, 1 inventory, 2 reset-to-ready |
| resp_payload | output | 72 | Reply payload, low byte sent first |

## Verification
The hardest state to reach is the late part of a 16-slot sequence. Here the reply depends on the identifier bits sitting just above a mask of random length. Reaching it takes a full chain of end delimiters, each spaced by a complete guard interval.

The bench draws random identifiers and mask lengths. For each one it computes the one slot that must answer, then walks all sixteen slots and checks that exactly that slot replies. Quiet-Hold across a field dropout is also reached only by a sequence: an addressed entry, a dropout with the retention input held either way, and an inventory probe to reveal the resulting state.

// File: rtl/inv_pkg.sv
package inv_pkg;

    localparam int UID_W   = 64;
    localparam int MLEN_W  = 7;
    localparam int PAY_W   = UID_W + 8;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_READY  = 2'd1,
        ST_QUIET  = 2'd2,
        ST_QHOLD  = 2'd3
    } tag_st_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_INV  = 2'd1,
        RK_ACK  = 2'd2
    } rsp_kind_e;

    localparam logic [7:0] CMD_INVENTORY = 8'h01;
    localparam logic [7:0] CMD_STAYQUIET = 8'h02;
    localparam logic [7:0] CMD_TOREADY   = 8'h26;
    localparam logic [7:0] CMD_QHOLD     = 8'hAA;
    localparam logic [7:0] MFG_OWN       = 8'h16;

    localparam int FB_INV    = 2;
    localparam int FB_EXT    = 3;
    localparam int FB_FILTER = 4;
    localparam int FB_ADDR   = 5;
    localparam int FB_RSVD   = 7;

    typedef struct packed {
        logic inv_start;
        logic one_slot;
        logic go_quiet;
        logic go_qhold;
        logic go_ready;
    } req_act_t;

    function automatic logic [UID_W-1:0] low_ones(input logic [7:0] n);
        logic [UID_W:0] t;
        t = ({{UID_W{1'b0}}, 1'b1} << n) - {{UID_W{1'b0}}, 1'b1};
        return t[UID_W-1:0];
    endfunction

    function automatic logic slot_hit(input logic [UID_W-1:0] uid,
                                      input logic [UID_W-1:0] slot_ext,
                                      input logic [7:0]       sbits,
                                      input logic [MLEN_W-1:0] mlen,
                                      input logic [UID_W-1:0] mask);
        logic [UID_W-1:0] ref_v;
        logic [UID_W-1:0] keep;
        ref_v = (mask & low_ones({1'b0, mlen})) | (slot_ext << mlen);
        keep  = low_ones({1'b0, mlen} + sbits);
        return ((uid ^ ref_v) & keep) == '0;
    endfunction

endpackage

// File: rtl/inv_req_decode.sv
module inv_req_decode
    import inv_pkg::*;
#(
    parameter int SLOT_BITS = 4
) (
    input  tag_st_e            st,
    input  logic               req_valid,
    input  logic               crc_ok,
    input  logic [7:0]         flags,
    input  logic [7:0]         cmd,
    input  logic [7:0]         mfg,
    input  logic [MLEN_W-1:0]  mlen,
    input  logic               uid_match,
    output req_act_t           act
);
    localparam int MAX_LEN_ONE  = UID_W;
    localparam int MAX_LEN_MANY = UID_W - SLOT_BITS;

    logic base_ok, inv_f, addr_f, one_f, len_ok, addr_ok, powered;
    logic unused_flag_bits;

    assign unused_flag_bits = ^{flags[1:0], flags[6]};

    always_comb begin
        powered = (st != ST_OFF);
        base_ok = req_valid && crc_ok && powered &&
                  !flags[FB_EXT] && !flags[FB_RSVD] && !flags[FB_FILTER];
        inv_f   = flags[FB_INV];
        addr_f  = !inv_f && flags[FB_ADDR];
        one_f   = inv_f && flags[FB_ADDR];
        len_ok  = one_f ? (int'(mlen) <= MAX_LEN_ONE) : (int'(mlen) <= MAX_LEN_MANY);
        addr_ok = !addr_f || uid_match;

        act           = '0;
        act.one_slot  = one_f;
        act.inv_start = base_ok && inv_f && (cmd == CMD_INVENTORY) &&
                        (st == ST_READY) && len_ok;
        act.go_quiet  = base_ok && !inv_f && (cmd == CMD_STAYQUIET) &&
                        addr_f && uid_match;
        act.go_qhold  = base_ok && !inv_f && (cmd == CMD_QHOLD) &&
                        addr_f && uid_match && (mfg == MFG_OWN);
        act.go_ready  = base_ok && !inv_f && (cmd == CMD_TOREADY) && addr_ok;
    end
endmodule

// File: rtl/inv_tag_state.sv
module inv_tag_state
    import inv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     field_on,
    input  logic     retain_expired,
    input  req_act_t act,
    output tag_st_e  st
);
    logic keep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_OFF;
            keep_q <= 1'b0;
        end else if (!field_on) begin
            st <= ST_OFF;
            if (st == ST_QHOLD)
                keep_q <= 1'b1;
            else if (st != ST_OFF || retain_expired)
                keep_q <= 1'b0;
        end else if (st == ST_OFF) begin
            st     <= (keep_q && !retain_expired) ? ST_QHOLD : ST_READY;
            keep_q <= 1'b0;
        end else if (act.go_ready) begin
            st <= ST_READY;
        end else if (act.go_qhold) begin
            st <= ST_QHOLD;
        end else if (act.go_quiet) begin
            st <= ST_QUIET;
        end
    end
endmodule

// File: rtl/inv_slot_loop.sv
module inv_slot_loop
    import inv_pkg::*;
#(
    parameter int SLOT_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 one_slot,
    input  logic [MLEN_W-1:0]    mlen,
    input  logic [UID_W-1:0]     mask,
    input  logic [UID_W-1:0]     uid,
    input  logic                 eof_seen,
    input  logic                 abort,
    output logic                 active,
    output logic                 single,
    output logic [SLOT_BITS-1:0] slot,
    output logic                 advance,
    output logic                 hit
);
    localparam logic [SLOT_BITS-1:0] LAST_SLOT = {SLOT_BITS{1'b1}};

    logic [MLEN_W-1:0] mlen_q;
    logic [UID_W-1:0]  mask_q;
    logic [7:0]        sbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            single <= 1'b0;
            slot   <= '0;
            mlen_q <= '0;
            mask_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            single <= one_slot;
            slot   <= '0;
            mlen_q <= mlen;
            mask_q <= mask;
        end else if (abort) begin
            active <= 1'b0;
        end else if (eof_seen && active) begin
            if (advance)
                slot <= slot + 1'b1;
            else
                active <= 1'b0;
        end
    end

    always_comb begin
        advance = eof_seen && active && !abort && !start && !single && (slot != LAST_SLOT);
        sbits   = single ? 8'd0 : 8'(SLOT_BITS);
        hit     = active && slot_hit(uid, {{(UID_W-SLOT_BITS){1'b0}}, slot}, sbits, mlen_q, mask_q);
    end
endmodule

// File: rtl/inv_reply_timer.sv
module inv_reply_timer
    import inv_pkg::*;
#(
    parameter int T1_CYC = 4352
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rsp_kind_e load_kind,
    input  logic      restart,
    input  logic      cancel,
    output logic      expire,
    output rsp_kind_e kind
);
    localparam int CNT_W = $clog2(T1_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(T1_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            kind <= RK_NONE;
        end else if (load) begin
            cnt  <= CNT_FULL;
            kind <= load_kind;
        end else if (cancel) begin
            cnt  <= '0;
        end else if (cnt != '0 && restart) begin
            cnt  <= CNT_FULL;
        end else if (cnt != '0) begin
            cnt  <= cnt - CNT_ONE;
        end
    end

    assign expire = (cnt == CNT_ONE) && !load && !cancel && !restart;
endmodule

// File: rtl/inv_slot_ctrl.sv
module inv_slot_ctrl
    import inv_pkg::*;
#(
    parameter int T1_CYC    = 4352,
    parameter int SLOT_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                field_on,
    input  logic                retain_expired,
    input  logic [UID_W-1:0]    tag_uid,
    input  logic                req_valid,
    input  logic                req_crc_ok,
    input  logic [7:0]          req_flags,
    input  logic [7:0]          req_cmd,
    input  logic [7:0]          req_mfg,
    input  logic [MLEN_W-1:0]   req_mask_len,
    input  logic [UID_W-1:0]    req_mask,
    input  logic                req_uid_match,
    input  logic                sof_seen,
    input  logic                eof_seen,
    input  logic                full_mod,
    output logic                resp_fire,
    output logic [1:0]          resp_kind,
    output logic [PAY_W-1:0]    resp_payload
);
    tag_st_e                tag_st;
    req_act_t               act;
    logic                   loop_active, loop_single, loop_adv, loop_hit;
    logic [SLOT_BITS-1:0]   loop_slot;
    logic                   abort, t_load, t_expire, fire_d;
    rsp_kind_e              t_kind, t_load_kind;

    inv_req_decode #(.SLOT_BITS(SLOT_BITS)) dec_i (
        .st(tag_st), .req_valid(req_valid), .crc_ok(req_crc_ok),
        .flags(req_flags), .cmd(req_cmd), .mfg(req_mfg),
        .mlen(req_mask_len), .uid_match(req_uid_match), .act(act)
    );

    inv_tag_state st_i (
        .clk(clk), .rst(rst), .field_on(field_on),
        .retain_expired(retain_expired), .act(act), .st(tag_st)
    );

    assign abort = sof_seen || req_valid || !field_on;

    inv_slot_loop #(.SLOT_BITS(SLOT_BITS)) loop_i (
        .clk(clk), .rst(rst), .start(act.inv_start), .one_slot(act.one_slot),
        .mlen(req_mask_len), .mask(req_mask), .uid(tag_uid),
        .eof_seen(eof_seen), .abort(abort), .active(loop_active),
        .single(loop_single), .slot(loop_slot), .advance(loop_adv), .hit(loop_hit)
    );

    assign t_load      = act.inv_start || loop_adv || act.go_ready;
    assign t_load_kind = act.go_ready ? RK_ACK : RK_INV;

    inv_reply_timer #(.T1_CYC(T1_CYC)) tmr_i (
        .clk(clk), .rst(rst), .load(t_load), .load_kind(t_load_kind),
        .restart(full_mod), .cancel(abort), .expire(t_expire), .kind(t_kind)
    );

    assign fire_d = t_expire && ((t_kind == RK_ACK) || (t_kind == RK_INV && loop_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_fire    <= 1'b0;
            resp_kind    <= RK_NONE;
            resp_payload <= '0;
        end else begin
            resp_fire    <= fire_d;
            resp_kind    <= fire_d ? t_kind : RK_NONE;
            resp_payload <= (fire_d && t_kind == RK_INV) ? {tag_uid, 8'h00} : '0;
        end
    end
endmodule

// File: rtl/inv_slot_ctrl_chk.sv
module inv_slot_ctrl_chk #(
    parameter int SLOT_BITS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 field_on,
    input logic                 req_valid,
    input logic                 req_crc_ok,
    input logic                 sof_seen,
    input logic                 eof_seen,
    input logic                 resp_fire,
    input logic [1:0]           resp_kind,
    input logic [1:0]           state,
    input logic                 loop_active,
    input logic                 loop_single,
    input logic [SLOT_BITS-1:0] slot
);
    AST_DARK_SILENT: assert property (@(posedge clk) disable iff (rst)
        !field_on |=> !resp_fire);  // R1
    AST_BADCRC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_crc_ok) |=> !resp_fire);  // R2
    AST_BADCRC_KEEP_STATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_crc_ok && field_on && state != 2'd0) |=> state == $past(state));  // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (loop_active && eof_seen && !sof_seen && !req_valid && field_on &&
         !loop_single && slot != {SLOT_BITS{1'b1}})
        |=> (loop_active && slot == SLOT_BITS'($past(slot) + 1'b1)));  // R3
    AST_SINGLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (loop_active && loop_single) |-> slot == '0);  // R4
    AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_fire |=> !resp_fire);  // R6
    AST_SOF_ENDS_LOOP: assert property (@(posedge clk) disable iff (rst)
        (sof_seen && !req_valid) |=> !loop_active);  // R7
    AST_INV_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
        (resp_fire && resp_kind == 2'd1) |-> state == 2'd1);  // R8
endmodule

bind inv_slot_ctrl inv_slot_ctrl_chk #(.SLOT_BITS(SLOT_BITS)) chk_i (
    .clk(clk), .rst(rst), .field_on(field_on), .req_valid(req_valid),
    .req_crc_ok(req_crc_ok), .sof_seen(sof_seen), .eof_seen(eof_seen),
    .resp_fire(resp_fire), .resp_kind(resp_kind), .state(tag_st),
    .loop_active(loop_active), .loop_single(loop_single), .slot(loop_slot)
);

// File: tb/inv_slot_ctrl_tb_top.sv
module inv_slot_ctrl_tb_top;
    localparam int T1 = 24;
    localparam logic [7:0] F_INV = 8'h04, F_B5 = 8'h20, F_B4 = 8'h10,
                           F_EXT = 8'h08, F_RSV = 8'h80;

    logic clk = 1'b0, rst = 1'b1, field_on = 1'b1, retain_expired = 1'b0;
    logic [63:0] uid = 64'h0;
    logic req_valid = 1'b0, req_crc_ok = 1'b1, req_uid_match = 1'b0;
    logic [7:0] req_flags = 8'h0, req_cmd = 8'h0, req_mfg = 8'h0;
    logic [6:0] req_mask_len = 7'h0;
    logic [63:0] req_mask = 64'h0;
    logic sof_seen = 1'b0, eof_seen = 1'b0, full_mod = 1'b0;
    logic resp_fire;
    logic [1:0] resp_kind;
    logic [71:0] resp_payload;
    int checks = 0, fails = 0;

    inv_slot_ctrl #(.T1_CYC(T1)) dut_i (
        .clk(clk), .rst(rst), .field_on(field_on), .retain_expired(retain_expired),
        .tag_uid(uid), .req_valid(req_valid), .req_crc_ok(req_crc_ok),
        .req_flags(req_flags), .req_cmd(req_cmd), .req_mfg(req_mfg),
        .req_mask_len(req_mask_len), .req_mask(req_mask), .req_uid_match(req_uid_match),
        .sof_seen(sof_seen), .eof_seen(eof_seen), .full_mod(full_mod),
        .resp_fire(resp_fire), .resp_kind(resp_kind), .resp_payload(resp_payload)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] lowm(input int n);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] fl, input logic [7:0] cmd, input logic [7:0] mfg,
                        input int ml, input logic [63:0] mk, input bit um, input bit crc);
        @(negedge clk);
        req_flags = fl; req_cmd = cmd; req_mfg = mfg; req_mask_len = 7'(ml);
        req_mask = mk; req_uid_match = um; req_crc_ok = crc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_eof();
        @(negedge clk); eof_seen = 1'b1; @(negedge clk); eof_seen = 1'b0;
    endtask
    task automatic pulse_sof();
        @(negedge clk); sof_seen = 1'b1; @(negedge clk); sof_seen = 1'b0;
    endtask
    task automatic pulse_fm();
        @(negedge clk); full_mod = 1'b1; @(negedge clk); full_mod = 1'b0;
    endtask

    task automatic watch(output int at, output logic [1:0] k, output logic [71:0] p);
        at = 0; k = 2'd0; p = '0;
        for (int i = 1; i <= T1 + 6; i++) begin
            if (resp_fire && at == 0) begin
                at = i; k = resp_kind; p = resp_payload;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_inv(input string rq);
        int at; logic [1:0] k; logic [71:0] p;
        watch(at, k, p);
        chk(at == T1 + 1, rq, "reply cycle", 72'(at), 72'(T1 + 1));
        if (at != 0) begin
            chk(k == 2'd1, rq, "kind", 72'(k), 72'd1);
            chk(p == {uid, 8'h00}, "R12", "payload", p, {uid, 8'h00});
        end
    endtask

    task automatic expect_ack(input string rq);
        int at; logic [1:0] k; logic [71:0] p;
        watch(at, k, p);
        chk(at == T1 + 1, rq, "ack cycle", 72'(at), 72'(T1 + 1));
        chk(k == 2'd2 && p == '0, rq, "ack kind", {p[69:0], k}, 72'd2);
    endtask

    task automatic expect_none(input string rq);
        int at; logic [1:0] k; logic [71:0] p;
        watch(at, k, p);
        chk(at == 0, rq, "silent", 72'(at), 72'd0);
    endtask

    task automatic probe(input bit ready, input string rq);
        send(F_INV | F_B5, 8'h01, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        if (ready) expect_inv(rq); else expect_none(rq);
    endtask

    task automatic field_cycle(input bit expired);
        @(negedge clk); field_on = 1'b0; retain_expired = expired;
        repeat (3) @(negedge clk);
        field_on = 1'b1;
        repeat (2) @(negedge clk);
        retain_expired = 1'b0;
    endtask

    initial begin
        #(150000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        uid = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(negedge clk);
        chk(resp_fire == 1'b0, "R1", "fire in reset", 72'(resp_fire), 72'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 / R4 / R12: ready after reset, single slot, no mask
        probe(1'b1, "R1");
        // R4: single slot, exact mask
        send(F_INV | F_B5, 8'h01, 8'h00, 20, uid & lowm(20), 1'b0, 1'b1);
        expect_inv("R4");
        send(F_INV | F_B5, 8'h01, 8'h00, 20, (uid & lowm(20)) ^ 64'h8_0000, 1'b0, 1'b1);
        expect_none("R4");

        // R6: full-depth pause restarts the guard interval
        send(F_INV | F_B5, 8'h01, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        repeat (9) @(negedge clk);
        pulse_fm();
        expect_inv("R6");

        // R2: flag and checksum rejections
        send(F_INV | F_B5, 8'h01, 8'h00, 0, 64'h0, 1'b0, 1'b0);
        expect_none("R2");
        send(F_INV | F_B5 | F_B4, 8'h01, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        expect_none("R2");
        send(F_INV | F_B5 | F_EXT, 8'h01, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        expect_none("R2");
        send(F_INV | F_B5 | F_RSV, 8'h01, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        expect_none("R2");
        send(F_B5, 8'h02, 8'h00, 0, 64'h0, 1'b1, 1'b0);
        probe(1'b1, "R2");
        send(F_B5 | F_B4, 8'h02, 8'h00, 0, 64'h0, 1'b1, 1'b1);
        probe(1'b1, "R2");

        // R5: mask length limits
        uid = 64'h0FED_CBA9_8765_4321;
        send(F_INV, 8'h01, 8'h00, 60, uid & lowm(60), 1'b0, 1'b1);
        expect_inv("R5");
        send(F_INV, 8'h01, 8'h00, 61, uid & lowm(61), 1'b0, 1'b1);
        expect_none("R5");
        send(F_INV | F_B5, 8'h01, 8'h00, 64, uid, 1'b0, 1'b1);
        expect_inv("R5");
        send(F_INV | F_B5, 8'h01, 8'h00, 65, uid, 1'b0, 1'b1);
        expect_none("R5");

        // R3: random 16-slot sequences
        for (int run = 0; run < 8; run++) begin
            int ml, exp_slot;
            logic [63:0] mk;
            uid = {$urandom, $urandom};
            ml = (run == 0) ? 0 : int'($urandom % 13);
            mk = uid & lowm(ml);
            exp_slot = int'((uid >> ml) & 64'hF);
            if (run == 7 && ml > 0) begin
                mk[0] = ~mk[0];
                exp_slot = -1;
            end
            send(F_INV, 8'h01, 8'h00, ml, mk, 1'b0, 1'b1);
            for (int s = 0; s < 16; s++) begin
                if (s > 0) pulse_eof();
                if (s == exp_slot) expect_inv("R3"); else expect_none("R3");
            end
        end

        // R4: random single-slot, matching and not
        for (int run = 0; run < 8; run++) begin
            int ml;
            logic [63:0] mk;
            uid = {$urandom, $urandom};
            ml = 1 + int'($urandom % 64);
            mk = uid & lowm(ml);
            if (run[0]) begin
                mk[ml - 1] = ~mk[ml - 1];
                send(F_INV | F_B5, 8'h01, 8'h00, ml, mk, 1'b0, 1'b1);
                expect_none("R4");
            end else begin
                send(F_INV | F_B5, 8'h01, 8'h00, ml, mk, 1'b0, 1'b1);
                expect_inv("R4");
            end
        end

        // R7: start delimiter ends the sequence
        uid = 64'h0000_0000_0000_0035;
        send(F_INV, 8'h01, 8'h00, 4, 64'h5, 1'b0, 1'b1);
        expect_none("R7");
        pulse_eof();
        expect_none("R7");
        pulse_sof();
        pulse_eof();
        expect_none("R7");
        pulse_eof();
        expect_none("R7");

        // R8: stay quiet needs address and match
        send(F_B5, 8'h02, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        probe(1'b1, "R8");
        send(8'h00, 8'h02, 8'h00, 0, 64'h0, 1'b1, 1'b1);
        probe(1'b1, "R8");
        send(F_B5, 8'h02, 8'h00, 0, 64'h0, 1'b1, 1'b1);
        expect_none("R12");
        probe(1'b0, "R8");

        // R9: non-addressed reset to ready from Quiet
        send(8'h00, 8'h26, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        expect_ack("R9");
        probe(1'b1, "R9");
        // R1: Quiet lost over a field dropout
        send(F_B5, 8'h02, 8'h00, 0, 64'h0, 1'b1, 1'b1);
        field_cycle(1'b0);
        probe(1'b1, "R1");

        // R10: quiet-hold entry conditions
        send(F_B5, 8'hAA, 8'h15, 0, 64'h0, 1'b1, 1'b1);
        probe(1'b1, "R10");
        send(8'h00, 8'hAA, 8'h16, 0, 64'h0, 1'b1, 1'b1);
        probe(1'b1, "R10");
        send(F_B5, 8'hAA, 8'h16, 0, 64'h0, 1'b1, 1'b1);
        expect_none("R12");
        probe(1'b0, "R10");

        // R11: retention kept, then expired
        field_cycle(1'b0);
        probe(1'b0, "R11");
        field_cycle(1'b1);
        probe(1'b1, "R11");

        // R10: stay quiet moves quiet-hold to Quiet, which a dropout clears
        send(F_B5, 8'hAA, 8'h16, 0, 64'h0, 1'b1, 1'b1);
        send(F_B5, 8'h02, 8'h00, 0, 64'h0, 1'b1, 1'b1);
        field_cycle(1'b0);
        probe(1'b1, "R10");

        // R9: addressed reset to ready releases quiet-hold only on match
        send(F_B5, 8'hAA, 8'h16, 0, 64'h0, 1'b1, 1'b1);
        send(F_B5, 8'h26, 8'h00, 0, 64'h0, 1'b0, 1'b1);
        expect_none("R9");
        probe(1'b0, "R9");
        send(F_B5, 8'h26, 8'h00, 0, 64'h0, 1'b1, 1'b1);
        expect_ack("R9");
        probe(1'b1, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule